// File: doc/BRIEF.md
# Shared-Line Serial ADC Host Controller

This block runs the host side of an 8-channel, 12-bit serial converter whose single data pin carries traffic in both directions. It generates the serial clock from the system clock, drives two separate active-low chip selects (one for the analog multiplexer and one for the converter), shifts a four-bit channel address out onto the shared line, lets go of that line, and then shifts the conversion result back in. The pad itself stays outside the block. The block provides the outgoing bit, an output enable and the incoming bit, and the tristate buffer at the chip edge joins them into one wire.

A user logic request is one `start_i` pulse together with a channel number, a divider setting and a reuse flag. A full frame selects the channel and then converts. When reuse is requested and a channel has already been selected since reset, the controller runs a shorter frame on the converter select alone and sends no address, so a single selection can serve many conversions. Each result comes back with a one-cycle strobe.

Top module: `adc_link_ctrl`

## Requirements
- R1: After reset the serial clock is low, both chip selects are high, the data output enable is low, and `valid_o` and `busy_o` are low.
- R2: Each serial bit cycle holds the clock low for H system clocks and then high for H system clocks. H is `half_period_i`, captured when a start is accepted, and a value of 0 acts as 1. The serial clock stays low whenever the converter select is high.
- R3: A full frame drives four address bits on the line, one per serial cycle in cycles 1 to 4, each stable across that cycle's rising edge: first an enable bit equal to 1, then channel bits 2, 1 and 0. The output enable is high only while the multiplexer select is low.
- R4: The output enable falls on the falling serial edge that ends cycle 4 and stays low for the rest of the frame. This is earlier than the fifth falling edge, and the host never drives the line while the device drives it.
- R5: A full frame lasts 18 serial cycles. Cycle 5 is a turnaround, cycle 6 carries the null bit, and cycles 7 to 18 carry result bits 11 down to 0, each sampled on the rising edge of its cycle.
- R6: The value of the null bit has no effect on the result.
- R7: On the system clock edge that ends the last high half, both chip selects rise, `result_o` takes the 12 captured bits (the first one captured is the MSB), and `valid_o` is high for exactly that one clock.
- R8: `busy_o` is high from the clock after an accepted start through the `valid_o` clock. A start seen while `busy_o` is high, including the `valid_o` clock itself, is ignored. A start in the following clock is accepted.
- R9: If reuse is set and a full frame has completed since reset, the frame uses only the converter select and never asserts the output enable. It lasts 14 cycles: cycle 2 is the null bit and cycles 3 to 14 are bits 11 to 0. The channel input is ignored and the result comes from the previously selected channel.
- R10: If reuse is set but no full frame has completed since reset, a full frame runs using the channel input.
- R11: In a full frame both chip selects are low together for the whole frame, and the multiplexer select is never low without the converter select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, one clock |
| chan_i | input | 3 | Channel to select in a full frame |
| reuse_i | input | 1 | Keep the last selected channel and skip the address phase |
| half_period_i | input | DIV_W | System clocks per serial clock half period |
| busy_o | output | 1 | Request in progress |
| valid_o | output | 1 | One-clock result strobe |
| result_o | output | 12 | Last conversion result |
| sclk_o | output | 1 | Serial clock, idle low |
| cs_mux_n_o | output | 1 | Multiplexer select, active low |
| cs_adc_n_o | output | 1 | Converter select, active low |
| sd_out_o | output | 1 | Bit driven onto the shared data line |
| sd_oe_o | output | 1 | Output enable of the shared line driver |
| sd_in_i | input | 1 | Level seen on the shared data line |

## Verification
The result strobe and a new request can land in the same system clock. At that moment the controller is closing one frame while the user is already asking for the next. The bench drives `start_i` in exactly the clock where `valid_o` is high, then looks at the ports in the following clock: `busy_o` and `cs_adc_n_o` must show that no frame began. It then drives a start in the next clock and expects it to be accepted. A second pairing is the host releasing the line and the device taking it over. A behavioural device model on the resolved wire counts any clock in which both drive, and it also counts an output enable that is still high at the fifth falling edge.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;
  localparam int RES_W     = 12;
  localparam int CH_W      = 3;
  localparam int ADDR_BITS = CH_W + 1;
  localparam int TURN_CYC  = 1;
  localparam int ACQ_CYC   = 1;
  localparam int FULL_CYC  = ADDR_BITS + TURN_CYC + 1 + RES_W;
  localparam int CONV_CYC  = ACQ_CYC + 1 + RES_W;
  localparam int CYC_W     = $clog2(FULL_CYC + 1);
  localparam int PH_W      = CYC_W + 1;
  localparam int CAP_W     = $clog2(RES_W + 1);

  typedef enum logic {FR_FULL = 1'b0, FR_CONV = 1'b1} frame_t;

  // serial cycles in one frame of the given kind
  function automatic logic [CYC_W-1:0] frame_len(input frame_t kind);
    return (kind == FR_FULL) ? CYC_W'(FULL_CYC) : CYC_W'(CONV_CYC);
  endfunction

  // first cycle carrying a result bit (MSB)
  function automatic logic [CYC_W-1:0] first_bit_cycle(input frame_t kind);
    return frame_len(kind) - CYC_W'(RES_W) + CYC_W'(1);
  endfunction

  // whether the host owns the line during a given cycle
  function automatic logic host_drives(input frame_t kind, input logic [CYC_W-1:0] cyc);
    return (kind == FR_FULL) && (cyc >= CYC_W'(1)) && (cyc <= CYC_W'(ADDR_BITS));
  endfunction

  // address bit for a cycle: enable first, then channel MSB to LSB
  function automatic logic addr_bit(input logic [CH_W-1:0] ch, input logic [CYC_W-1:0] cyc);
    logic [ADDR_BITS-1:0] word;
    logic b;
    word = {1'b1, ch};
    b = 1'b0;
    for (int i = 0; i < ADDR_BITS; i++) begin
      if (cyc == CYC_W'(i + 1)) b = word[ADDR_BITS-1-i];
    end
    return b;
  endfunction
endpackage

// File: rtl/adc_link_clkdiv.sv
module adc_link_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             half_end_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit;

  always_comb begin
    limit      = (half_i == '0) ? '0 : half_i - DIV_W'(1);
    half_end_o = run_i && (cnt_q == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (!run_i || half_end_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + DIV_W'(1);
  end

  assert_div_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= limit));
endmodule

// File: rtl/adc_link_seq.sv
module adc_link_seq
  import adc_link_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic             reuse_i,
  input  logic [DIV_W-1:0] half_period_i,
  input  logic             half_end_i,
  output logic             run_o,
  output logic [DIV_W-1:0] half_o,
  output frame_t           kind_o,
  output logic [CH_W-1:0]  ch_o,
  output logic [CYC_W-1:0] cyc_o,
  output logic             capture_o,
  output logic             finish_o,
  output logic             sclk_o,
  output logic             cs_mux_n_o,
  output logic             cs_adc_n_o,
  output logic             busy_o,
  output logic             valid_o
);
  logic             run_q, done_q, sel_ok_q;
  frame_t           kind_q, kind_next;
  logic [CH_W-1:0]  ch_q;
  logic [DIV_W-1:0] half_q;
  logic [PH_W-1:0]  ph_q, last_ph;
  logic [CYC_W-1:0] cyc;
  logic             accept;

  always_comb begin
    cyc       = ph_q[PH_W-1:1] + CYC_W'(1);
    last_ph   = {frame_len(kind_q), 1'b0} - PH_W'(1);
    busy_o    = run_q || done_q;
    accept    = start_i && !busy_o;
    kind_next = (reuse_i && sel_ok_q) ? FR_CONV : FR_FULL;
    capture_o = run_q && half_end_i && !ph_q[0] && (cyc >= first_bit_cycle(kind_q));
    finish_o  = run_q && half_end_i && (ph_q == last_ph);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      done_q   <= 1'b0;
      sel_ok_q <= 1'b0;
      kind_q   <= FR_FULL;
      ch_q     <= '0;
      half_q   <= '0;
      ph_q     <= '0;
    end else begin
      done_q <= finish_o;
      if (accept) begin
        run_q  <= 1'b1;
        ph_q   <= '0;
        kind_q <= kind_next;
        half_q <= half_period_i;
        if (kind_next == FR_FULL) ch_q <= chan_i;
      end else if (run_q && half_end_i) begin
        if (ph_q == last_ph) begin
          run_q <= 1'b0;
          ph_q  <= '0;
          if (kind_q == FR_FULL) sel_ok_q <= 1'b1;
        end else begin
          ph_q <= ph_q + PH_W'(1);
        end
      end
    end
  end

  always_comb begin
    run_o      = run_q;
    half_o     = half_q;
    kind_o     = kind_q;
    ch_o       = ch_q;
    cyc_o      = cyc;
    sclk_o     = run_q && ph_q[0];
    cs_adc_n_o = !run_q;
    cs_mux_n_o = !(run_q && (kind_q == FR_FULL));
    valid_o    = done_q;
  end

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_adc_n_o |-> !sclk_o);
  assert_mux_inside_adc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_mux_n_o |-> !cs_adc_n_o);
  assert_conv_needs_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && kind_q == FR_CONV) |-> sel_ok_q);
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(ch_q) && $stable(half_q) && $stable(kind_q)));
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_busy_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(valid_o));
  assert_frame_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_adc_n_o) |-> valid_o);
endmodule

// File: rtl/adc_link_shift.sv
module adc_link_shift
  import adc_link_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  frame_t           kind_i,
  input  logic [CH_W-1:0]  ch_i,
  input  logic [CYC_W-1:0] cyc_i,
  input  logic             capture_i,
  input  logic             finish_i,
  input  logic             din_i,
  output logic             dout_o,
  output logic             oe_o,
  output logic [RES_W-1:0] result_o
);
  logic [RES_W-1:0] shift_q, result_q;
  logic [CAP_W-1:0] cap_cnt_q;

  always_comb begin
    oe_o     = run_i && host_drives(kind_i, cyc_i);
    dout_o   = oe_o && addr_bit(ch_i, cyc_i);
    result_o = result_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q   <= '0;
      result_q  <= '0;
      cap_cnt_q <= '0;
    end else begin
      if (capture_i) begin
        shift_q   <= {shift_q[RES_W-2:0], din_i};
        cap_cnt_q <= cap_cnt_q + CAP_W'(1);
      end else if (!run_i) begin
        cap_cnt_q <= '0;
      end
      if (finish_i) result_q <= shift_q;
    end
  end

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && cyc_i > CYC_W'(ADDR_BITS)) |-> !oe_o);
  assert_bit_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    finish_i |-> (cap_cnt_q == CAP_W'(RES_W)));
endmodule

// File: rtl/adc_link_ctrl.sv
module adc_link_ctrl
  import adc_link_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic             reuse_i,
  input  logic [DIV_W-1:0] half_period_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [RES_W-1:0] result_o,
  output logic             sclk_o,
  output logic             cs_mux_n_o,
  output logic             cs_adc_n_o,
  output logic             sd_out_o,
  output logic             sd_oe_o,
  input  logic             sd_in_i
);
  logic             run, half_end, capture, finish;
  logic [DIV_W-1:0] half_q;
  frame_t           kind;
  logic [CH_W-1:0]  ch;
  logic [CYC_W-1:0] cyc;

  adc_link_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(run), .half_i(half_q), .half_end_o(half_end));

  adc_link_seq #(.DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i), .reuse_i(reuse_i),
    .half_period_i(half_period_i), .half_end_i(half_end), .run_o(run), .half_o(half_q),
    .kind_o(kind), .ch_o(ch), .cyc_o(cyc), .capture_o(capture), .finish_o(finish),
    .sclk_o(sclk_o), .cs_mux_n_o(cs_mux_n_o), .cs_adc_n_o(cs_adc_n_o),
    .busy_o(busy_o), .valid_o(valid_o));

  adc_link_shift u_shift (
    .clk(clk), .rst_n(rst_n), .run_i(run), .kind_i(kind), .ch_i(ch), .cyc_i(cyc),
    .capture_i(capture), .finish_i(finish), .din_i(sd_in_i), .dout_o(sd_out_o),
    .oe_o(sd_oe_o), .result_o(result_o));

  assert_drive_needs_mux_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe_o |-> !cs_mux_n_o);
endmodule

// File: tb/adc_link_ctrl_test.sv
module adc_link_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] chan = '0;
  logic reuse = 1'b0;
  logic [7:0] half = 8'd2;
  logic busy, valid, sclk, cs_mux_n, cs_adc_n, sd_out, sd_oe, sd_in;
  logic [11:0] result;

  always #4 clk = ~clk;

  adc_link_ctrl #(.DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .chan_i(chan), .reuse_i(reuse),
    .half_period_i(half), .busy_o(busy), .valid_o(valid), .result_o(result),
    .sclk_o(sclk), .cs_mux_n_o(cs_mux_n), .cs_adc_n_o(cs_adc_n),
    .sd_out_o(sd_out), .sd_oe_o(sd_oe), .sd_in_i(sd_in));

  function automatic logic [11:0] word_for(input int c);
    return 12'((c * 1171 + 2395) % 4096);
  endfunction

  // device model and monitors (single process)
  logic mdrv = 1'b0, mval = 1'b0, null_val = 1'b0;
  logic line;
  assign line  = sd_oe ? sd_out : (mdrv ? mval : 1'b1);
  assign sd_in = line;

  int clr_seq = 0, clr_seen = 0;
  int rises = 0, falls = 0, contention = 0, late_rel = 0, hcur = 0, hmin = 0, hmax = 0;
  bit mux_seen = 0, oe_seen = 0, full = 0;
  logic [3:0] addr_sh = '0, addr_rx = '0;
  logic [2:0] mux_ch = '0;
  logic [11:0] word = '0;
  logic cs_prev = 1'b1, sclk_prev = 1'b0;

  always @(negedge clk) begin
    int c, nullc;
    if (clr_seen != clr_seq) begin
      clr_seen = clr_seq;
      rises = 0; falls = 0; contention = 0; late_rel = 0;
      hcur = 0; hmin = 1000; hmax = 0; mux_seen = 0; oe_seen = 0; addr_rx = '0;
    end
    if (!cs_adc_n && cs_prev) begin
      full = !cs_mux_n; addr_sh = '0; mdrv = 1'b0;
    end
    if (!cs_adc_n) begin
      if (sclk && !sclk_prev) begin
        rises++;
        if (full && rises <= 4) addr_sh = {addr_sh[2:0], line};
        if (full && rises == 4) begin
          addr_rx = addr_sh;
          if (addr_sh[3]) mux_ch = addr_sh[2:0];
        end
      end
      if (!sclk && sclk_prev) begin
        falls++;
        if (full && falls == 5 && sd_oe) late_rel++;
        c = falls + 1;
        nullc = full ? 6 : 2;
        if (c == nullc) begin
          mdrv = 1'b1; mval = null_val; word = word_for(int'(mux_ch));
        end else if (c > nullc && c <= nullc + 12) begin
          mval = word[12 - (c - nullc)];
        end
      end
    end else begin
      mdrv = 1'b0;
    end
    if (!cs_mux_n) mux_seen = 1;
    if (sd_oe) oe_seen = 1;
    if (sd_oe && mdrv) contention++;
    if (sclk) hcur++;
    else if (hcur > 0) begin
      if (hcur < hmin) hmin = hcur;
      if (hcur > hmax) hmax = hcur;
      hcur = 0;
    end
    cs_prev = cs_adc_n;
    sclk_prev = sclk;
  end

  int errors = 0, total = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic kick(input logic [2:0] ch, input bit ru, input logic [7:0] hp);
    @(negedge clk);
    clr_seq++;
    chan = ch; reuse = ru; half = hp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valid(output bit got);
    got = 0;
    for (int i = 0; i < 4000; i++) begin
      if (valid) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(sclk == 0 && cs_mux_n == 1 && cs_adc_n == 1, "R1 idle bus", {sclk, cs_mux_n, cs_adc_n}, 3);
    chk(sd_oe == 0 && valid == 0 && busy == 0, "R1 idle flags", {sd_oe, valid, busy}, 0);
  endtask

  task automatic t_full(input logic [2:0] ch, input logic [7:0] hp, input int exp_h);
    bit got;
    kick(ch, 0, hp);
    chk(busy == 1, "R8 busy after start", busy, 1);
    chk(cs_mux_n == 0 && cs_adc_n == 0, "R11 both selects low", {cs_mux_n, cs_adc_n}, 0);
    wait_valid(got);
    chk(got, "R7 valid seen", got, 1);
    chk(result == word_for(int'(ch)), "R5 full result", result, word_for(int'(ch)));
    chk(cs_mux_n == 1 && cs_adc_n == 1 && busy == 1, "R7 selects high at valid", {cs_mux_n, cs_adc_n, busy}, 7);
    chk(rises == 18, "R5 cycles per full frame", rises, 18);
    chk(addr_rx == {1'b1, ch}, "R3 address bits", addr_rx, {1'b1, ch});
    chk(contention == 0 && late_rel == 0, "R4 release", contention + late_rel, 0);
    chk(hmin == exp_h && hmax == exp_h, "R2 high half width", hmax, exp_h);
    @(negedge clk);
    chk(valid == 0 && busy == 0, "R7 single valid", {valid, busy}, 0);
  endtask

  task automatic t_null();
    null_val = 1'b1;
    t_full(3'd7, 8'd1, 1);
    null_val = 1'b0;
    chk(result == word_for(7), "R6 null bit ignored", result, word_for(7));
  endtask

  task automatic t_reuse();
    bit got;
    kick(3'd0, 1, 8'd2);
    wait_valid(got);
    chk(got && result == word_for(7), "R9 reuse result", result, word_for(7));
    chk(mux_seen == 0 && oe_seen == 0, "R9 no mux select or drive", {mux_seen, oe_seen}, 0);
    chk(rises == 14, "R9 cycles per converter frame", rises, 14);
    @(negedge clk);
  endtask

  task automatic t_reuse_cold();
    bit got;
    do_reset();
    kick(3'd3, 1, 8'd2);
    wait_valid(got);
    chk(mux_seen == 1 && rises == 18, "R10 falls back to full frame", rises, 18);
    chk(result == word_for(3) && addr_rx == 4'b1011, "R10 new channel", result, word_for(3));
    @(negedge clk);
  endtask

  task automatic t_busy_ignore();
    bit got;
    kick(3'd1, 0, 8'd2);
    repeat (20) @(negedge clk);
    chan = 3'd6; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_valid(got);
    chk(result == word_for(1) && rises == 18, "R8 mid-frame start ignored", result, word_for(1));
    repeat (8) @(negedge clk);
    chk(cs_adc_n == 1 && busy == 0, "R8 no extra frame", {cs_adc_n, busy}, 2);
  endtask

  task automatic t_start_on_valid();
    bit got;
    kick(3'd4, 0, 8'd1);
    wait_valid(got);
    chan = 3'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 0 && cs_adc_n == 1, "R8 start in valid clock ignored", {busy, cs_adc_n}, 1);
    chan = 3'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1 && cs_mux_n == 0, "R8 start after valid accepted", {busy, cs_mux_n}, 2);
    clr_seq++;
    wait_valid(got);
    chk(result == word_for(2), "R8 back-to-back result", result, word_for(2));
    @(negedge clk);
  endtask

  initial begin
    bit wd = 0;
    fork
      begin
        t_reset();
        t_full(3'd5, 8'd2, 2);
        t_full(3'd2, 8'd1, 1);
        t_full(3'd6, 8'd0, 1);
        t_full(3'd0, 8'd3, 3);
        t_null();
        t_reuse();
        t_reuse_cold();
        t_busy_ignore();
        t_start_on_valid();
      end
      begin
        #(8 * 150000);
        wd = 1;
      end
    join_any
    disable fork;
    if (wd) chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule